// File: doc/BRIEF.md
# Start-stop serial transmitter with fractional stop length

This block turns parallel characters into start-stop serial frames. Each frame starts with a low start bit. The data bits follow, least significant first, then an optional parity bit, then a high stop period. The line idles high. The bit period is a fixed multiple of the input clock: 16, 32 or 64 clocks. The stop period is set in sixteenths of a bit, from a single sixteenth up to two whole bits. This covers the usual one and two stop-bit settings as well as shortened or stretched stops.

Characters arrive on a ready/valid handshake together with their frame settings. Those settings are captured at the moment the character is taken. The handshake is offered again in the final clock of the stop period. A waiting character therefore starts its start bit with no gap. A one-clock completion pulse marks the end of the stop period when no further character is waiting.

Top module: `afx_tx`

## Requirements
- R1: After reset `txOut` is 1, `inReady` is 1, `txBusy` is 0 and `txDone` is 0. Whenever the block is idle, `txOut` stays 1.
- R2: A frame is sent in this order: a start bit of 0, then the data bits least significant first, then the parity bit if enabled, then a stop period of 1.
- R3: The bit period is selected by `cfgRate`. A value of 0 gives 16 clocks, 1 gives 32 clocks, and 2 or 3 gives 64 clocks.
- R4: The number of data bits is `cfgBits`+1, from 1 to 8. Data bits above that count have no effect on the line.
- R5: `cfgParity` selects the parity bit. 1 is even (total ones including parity even), 2 is odd, 3 is always 1, 4 is always 0. 0 and 5 to 7 send no parity bit.
- R6: The stop period lasts `cfgStop`+1 sixteenths of a bit, and each sixteenth is 1, 2 or 4 clocks at the 16x, 32x or 64x rate. `cfgStop`=15 gives one stop bit and `cfgStop`=31 gives two.
- R7: `inReady` is 1 while idle and in the final clock of the stop period, and 0 otherwise. A character is taken on a rising edge with `inValid` and `inReady` both 1. `txOut` is 0 from the next clock.
- R8: `txBusy` is 1 from the clock after a character is taken until the stop period ends. `txDone` is 1 for exactly the final clock of the stop period, and only if `inValid` is 0 in that clock.
- R9: The data and all configuration inputs are sampled when a character is taken. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgRate | input | 2 | Clock-to-bit ratio select |
| cfgBits | input | 3 | Data bit count minus one |
| cfgParity | input | 3 | Parity mode |
| cfgStop | input | 5 | Stop length in sixteenths, minus one |
| inValid | input | 1 | Character offered |
| inData | input | 8 | Character to send |
| inReady | output | 1 | Character can be taken this clock |
| txOut | output | 1 | Serial line |
| txBusy | output | 1 | A frame is in progress |
| txDone | output | 1 | Stop period ended with nothing waiting |

## Verification
The assertions assume that `rstN` is released away from a clock edge. They also assume that the inputs settle between edges, so an accepted character and its settings are stable at the accepting edge. The stimulus changes every input only just after a falling edge. It draws rates, lengths, parity modes, stop lengths and data from a seeded random source. Mid-frame it scrambles the data and settings to probe the capture rule. Back-to-back chains present the next character during the final stop clock, which exercises the no-gap handover.

// File: rtl/afx_pkg.sv
package afx_pkg;

  typedef enum logic [1:0] {
    RATE_X16  = 2'd0,
    RATE_X32  = 2'd1,
    RATE_X64  = 2'd2,
    RATE_X64B = 2'd3
  } rate_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } parity_e;

  // Strobes from control to datapath, at most one per clock
  typedef struct packed {
    logic load;    // capture character, drive start bit
    logic shift;   // drive next data bit
    logic parity;  // drive parity bit
    logic stop;    // drive stop level
  } txStrobe_t;

  function automatic logic parityOn(input logic [2:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
           (mode == PAR_MARK) || (mode == PAR_SPACE);
  endfunction

endpackage

// File: rtl/afx_ctrl.sv
module afx_ctrl
  import afx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int SUBDIV   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    cfgRate,
  input  logic [$clog2(MAX_BITS)-1:0]   cfgBits,
  input  logic [2:0]                    cfgParity,
  input  logic [$clog2(2*SUBDIV)-1:0]   cfgStop,
  input  logic                          inValid,
  output logic                          inReady,
  output logic                          txBusy,
  output logic                          txDone,
  output txStrobe_t                     strobe
);

  localparam int BITS_W = $clog2(MAX_BITS);
  localparam int UNIT_W = $clog2(2*SUBDIV);
  localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(SUBDIV-1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } state_e;

  state_e              state, stateNext;
  logic [1:0]          rateLat;
  logic [BITS_W-1:0]   bitsLat;
  logic                parEnLat;
  logic [UNIT_W-1:0]   stopLat;
  logic [1:0]          divCnt, divLast;
  logic [UNIT_W-1:0]   unitCnt;
  logic [BITS_W-1:0]   bitCnt;
  logic                unitTick, bitEnd, stopEnd;

  // clocks per sixteenth minus one
  always_comb begin
    case (rate_e'(rateLat))
      RATE_X16: divLast = 2'd0;
      RATE_X32: divLast = 2'd1;
      default:  divLast = 2'd3;
    endcase
  end

  assign unitTick = (divCnt == divLast);
  assign bitEnd   = unitTick && (unitCnt == UNIT_LAST);
  assign stopEnd  = (state == ST_STOP) && unitTick && (unitCnt == stopLat);

  assign inReady = (state == ST_IDLE) || stopEnd;
  assign txBusy  = (state != ST_IDLE);
  assign txDone  = stopEnd && !inValid;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (inValid) begin
          strobe.load = 1'b1;
          stateNext   = ST_START;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          strobe.shift = 1'b1;
          stateNext    = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          if (bitCnt == bitsLat) begin
            if (parEnLat) begin
              strobe.parity = 1'b1;
              stateNext     = ST_PAR;
            end else begin
              strobe.stop = 1'b1;
              stateNext   = ST_STOP;
            end
          end else begin
            strobe.shift = 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (bitEnd) begin
          strobe.stop = 1'b1;
          stateNext   = ST_STOP;
        end
      end
      ST_STOP: begin
        if (stopEnd) begin
          if (inValid) begin
            strobe.load = 1'b1;
            stateNext   = ST_START;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rateLat  <= '0;
      bitsLat  <= '0;
      parEnLat <= 1'b0;
      stopLat  <= '0;
      divCnt   <= '0;
      unitCnt  <= '0;
      bitCnt   <= '0;
    end else begin
      state <= stateNext;
      if (strobe.load) begin
        rateLat  <= cfgRate;
        bitsLat  <= cfgBits;
        parEnLat <= parityOn(cfgParity);
        stopLat  <= cfgStop;
        divCnt   <= '0;
        unitCnt  <= '0;
      end else if (state == ST_IDLE) begin
        divCnt  <= '0;
        unitCnt <= '0;
      end else begin
        divCnt <= unitTick ? 2'd0 : divCnt + 2'd1;
        if (strobe.shift || strobe.parity || strobe.stop)
          unitCnt <= '0;
        else if (unitTick)
          unitCnt <= unitCnt + 1'b1;
      end
      if (state == ST_START && strobe.shift)
        bitCnt <= '0;
      else if (state == ST_DATA && strobe.shift)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  // R2: strobes never collide
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R4: data index never passes the captured count
  a_r4_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt <= bitsLat));

  // R6: stop window never overruns its programmed length
  a_r6_stop_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> (unitCnt <= stopLat));

endmodule

// File: rtl/afx_dpath.sv
module afx_dpath
  import afx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  txStrobe_t                    strobe,
  input  logic [MAX_BITS-1:0]          inData,
  input  logic [$clog2(MAX_BITS)-1:0]  cfgBits,
  input  logic [2:0]                   cfgParity,
  output logic                         txOut
);

  logic [MAX_BITS-1:0] shReg, dataMask;
  logic                parBit, parNext;

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++)
      dataMask[i] = (i <= int'(cfgBits));
  end

  always_comb begin
    case (parity_e'(cfgParity))
      PAR_EVEN:  parNext = ^(inData & dataMask);
      PAR_ODD:   parNext = ~^(inData & dataMask);
      PAR_MARK:  parNext = 1'b1;
      default:   parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOut  <= 1'b1;
      shReg  <= '0;
      parBit <= 1'b0;
    end else begin
      if (strobe.load) begin
        txOut  <= 1'b0;
        shReg  <= inData;
        parBit <= parNext;
      end else if (strobe.shift) begin
        txOut <= shReg[0];
        shReg <= shReg >> 1;
      end else if (strobe.parity) begin
        txOut <= parBit;
      end else if (strobe.stop) begin
        txOut <= 1'b1;
      end
    end
  end

  // R2: the line only moves on a control strobe
  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(|strobe) |=> $stable(txOut));

endmodule

// File: rtl/afx_tx.sv
module afx_tx
  import afx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int SUBDIV   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    cfgRate,
  input  logic [$clog2(MAX_BITS)-1:0]   cfgBits,
  input  logic [2:0]                    cfgParity,
  input  logic [$clog2(2*SUBDIV)-1:0]   cfgStop,
  input  logic                          inValid,
  input  logic [MAX_BITS-1:0]           inData,
  output logic                          inReady,
  output logic                          txOut,
  output logic                          txBusy,
  output logic                          txDone
);

  txStrobe_t strobe;

  afx_ctrl #(.MAX_BITS(MAX_BITS), .SUBDIV(SUBDIV)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgRate(cfgRate), .cfgBits(cfgBits),
    .cfgParity(cfgParity), .cfgStop(cfgStop), .inValid(inValid),
    .inReady(inReady), .txBusy(txBusy), .txDone(txDone), .strobe(strobe)
  );

  afx_dpath #(.MAX_BITS(MAX_BITS)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .cfgBits(cfgBits), .cfgParity(cfgParity), .txOut(txOut)
  );

  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);

  // R7: the start bit follows acceptance
  a_r7_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !txOut);

  // R7: ready is only offered while the line is high
  a_r7_ready_high: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txOut);

  // R8: completion leads to idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txBusy);

endmodule

// File: tb/tb_afx_tx.sv
module tb_afx_tx;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgRate = '0;
  logic [2:0] cfgBits = '0;
  logic [2:0] cfgParity = '0;
  logic [4:0] cfgStop = '0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inReady, txOut, txBusy, txDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afx_tx dut (
    .clk(clk), .rstN(rstN), .cfgRate(cfgRate), .cfgBits(cfgBits),
    .cfgParity(cfgParity), .cfgStop(cfgStop), .inValid(inValid),
    .inData(inData), .inReady(inReady), .txOut(txOut),
    .txBusy(txBusy), .txDone(txDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unitClocks(input logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit parOn(input logic [2:0] p);
    return (p >= 3'd1) && (p <= 3'd4);
  endfunction

  function automatic logic parVal(input logic [7:0] d, input int nb, input logic [2:0] p);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    case (p)
      3'd1: return x;
      3'd2: return ~x;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int frameLen(input logic [1:0] r, input logic [2:0] b,
                                  input logic [2:0] p, input logic [4:0] s);
    return unitClocks(r) * (16 * (2 + int'(b) + int'(parOn(p))) + int'(s) + 1);
  endfunction

  function automatic logic expBit(input int c, input logic [7:0] d, input logic [1:0] r,
                                  input logic [2:0] b, input logic [2:0] p);
    int nb = int'(b) + 1;
    int bi = (c / unitClocks(r)) / 16;
    if (bi == 0) return 1'b0;
    if (bi <= nb) return d[bi-1];
    if (parOn(p) && bi == nb + 1) return parVal(d, nb, p);
    return 1'b1;
  endfunction

  task automatic drive(input logic [7:0] d, input logic [1:0] r, input logic [2:0] b,
                       input logic [2:0] p, input logic [4:0] s);
    inData = d; cfgRate = r; cfgBits = b; cfgParity = p; cfgStop = s; inValid = 1'b1;
  endtask

  // Precondition: just after a falling edge, this frame's inputs driven and inReady high.
  task automatic runFrame(input logic [7:0] d, input logic [1:0] r, input logic [2:0] b,
                          input logic [2:0] p, input logic [4:0] s, input bit chain,
                          input logic [7:0] nd, input logic [1:0] nr, input logic [2:0] nb,
                          input logic [2:0] np, input logic [4:0] ns);
    int len = frameLen(r, b, p, s);
    int waveBad = 0, readyBad = 0, busyBad = 0, doneBad = 0;
    int firstBad = -1;
    logic badAct = 1'b0, badExp = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < len; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 0) begin
        // R9: scramble the captured inputs mid-frame
        inValid = 1'b0;
        inData = 8'($urandom); cfgRate = 2'($urandom); cfgBits = 3'($urandom);
        cfgParity = 3'($urandom); cfgStop = 5'($urandom);
      end
      if (c == len - 1 && chain) drive(nd, nr, nb, np, ns);
      #1;
      if (txOut !== expBit(c, d, r, b, p)) begin
        if (firstBad < 0) begin
          firstBad = c; badAct = txOut; badExp = expBit(c, d, r, b, p);
        end
        waveBad++;
      end
      if (inReady !== (c == len - 1)) readyBad++;
      if (txBusy !== 1'b1) busyBad++;
      if (txDone !== (c == len - 1 && !chain)) doneBad++;
    end
    check(waveBad == 0, $sformatf("R2 R3 R4 R5 R6 R9 line at clock %0d of frame", firstBad),
          badAct, badExp);
    check(readyBad == 0, "R7 ready only in final stop clock (bad clocks)", readyBad, 0);
    check(busyBad == 0, "R8 busy through frame (bad clocks)", busyBad, 0);
    check(doneBad == 0, "R8 done pulse placement (bad clocks)", doneBad, 0);
    if (!chain) begin
      @(negedge clk); #1;
      check(txOut === 1'b1 && txBusy === 1'b0 && inReady === 1'b1 && txDone === 1'b0,
            "R1 R8 idle after frame {out,busy,ready,done}",
            int'({txOut, txBusy, inReady, txDone}), 4'b1010);
    end
  endtask

  task automatic single(input logic [7:0] d, input logic [1:0] r, input logic [2:0] b,
                        input logic [2:0] p, input logic [4:0] s);
    @(negedge clk);
    drive(d, r, b, p, s);
    #1;
    check(inReady === 1'b1, "R7 ready while idle", int'(inReady), 1);
    runFrame(d, r, b, p, s, 1'b0, '0, '0, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3 + 2);
    // R1: reset state
    check(txOut === 1'b1 && inReady === 1'b1 && txBusy === 1'b0 && txDone === 1'b0,
          "R1 reset {out,ready,busy,done}", int'({txOut, inReady, txBusy, txDone}), 4'b1100);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(txOut === 1'b1 && txBusy === 1'b0, "R1 idle high after reset",
          int'(txOut), 1);

    // Directed corner cases
    single(8'hA5, 2'd0, 3'd7, 3'd0, 5'd15);   // R6 one stop bit, 16x
    single(8'hFF, 2'd2, 3'd0, 3'd3, 5'd0);    // R6 1/16 stop, 64x, mark
    single(8'h3C, 2'd1, 3'd7, 3'd2, 5'd31);   // R6 two stop bits, 32x, odd
    single(8'hE9, 2'd0, 3'd4, 3'd4, 5'd7);    // R4 upper bits ignored, space
    single(8'h07, 2'd3, 3'd2, 3'd1, 5'd20);   // R3 code 3 is 64x, even
    single(8'h5A, 2'd0, 3'd5, 3'd6, 5'd3);    // R5 code 6 sends no parity
    // R7 back-to-back chain
    @(negedge clk);
    drive(8'h81, 2'd0, 3'd7, 3'd1, 5'd0);
    runFrame(8'h81, 2'd0, 3'd7, 3'd1, 5'd0, 1'b1, 8'h42, 2'd1, 3'd3, 3'd2, 5'd9);
    runFrame(8'h42, 2'd1, 3'd3, 3'd2, 5'd9, 1'b0, '0, '0, '0, '0, '0);

    // Random frames, some chained
    begin
      logic [7:0] d; logic [1:0] r; logic [2:0] b, p; logic [4:0] s;
      bit chain;
      logic [7:0] nd; logic [1:0] nr; logic [2:0] nb, np; logic [4:0] ns;
      d = 8'($urandom); r = 2'($urandom); b = 3'($urandom);
      p = 3'($urandom); s = 5'($urandom);
      @(negedge clk);
      drive(d, r, b, p, s);
      #1;
      check(inReady === 1'b1, "R7 ready while idle", int'(inReady), 1);
      for (int k = 0; k < 50; k++) begin
        chain = (k < 49) && ($urandom % 3 == 0);
        nd = 8'($urandom); nr = 2'($urandom); nb = 3'($urandom);
        np = 3'($urandom); ns = 5'($urandom);
        runFrame(d, r, b, p, s, chain, nd, nr, nb, np, ns);
        d = nd; r = nr; b = nb; p = np; s = ns;
        if (!chain && k < 49) begin
          repeat ($urandom % 4) @(negedge clk);
          @(negedge clk);
          drive(d, r, b, p, s);
          #1;
          check(inReady === 1'b1, "R7 ready while idle", int'(inReady), 1);
        end
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule